// File: doc/BRIEF.md
# Trailing-One Sign and Coefficient Level Decoder

This block sits after coefficient-token decoding in a residual-block entropy decoder. The token stage has already found how many nonzero coefficients the 4x4 block holds and how many of them are trailing ±1 values. It then pulses `start_i` with those two counts while the bitstream window points just past the token. The block resolves every trailing-one sign at once from a captured three-bit register. It then decodes the other nonzero levels, one per cycle, from a unary prefix and a binary suffix. Each result goes into a coefficient-level buffer, stored in the order it was decoded.

Each cycle the block reports how many window bits it used. The surrounding bitstream shifter advances the window by that amount before the next cycle. When the last level has been stored, the block raises a one-cycle done strobe. The buffer then holds the finished list of levels until the next start.

Top module: `t1lev_dec`

## Requirements
- R1: While idle and `start_i` is low, `bits_used_o` is 0. In the cycle where `start_i` is taken, `bits_used_o` equals `t1s_i`, because that many sign bits are consumed.
- R2: Sign bits are the first `t1s_i` window bits at start, taken MSB first. A 0 bit gives +1 and a 1 bit gives −1 (all ones in two's complement). All of these values are written in the cycle after start, at buffer indices 0 to `t1s_i`−1. Captured bits beyond `t1s_i` change nothing, and buffer entries from `total_coeff_i` upward read 0.
- R3: The first non-trailing level is decoded in the same cycle as the sign write, and `bits_used_o` in that cycle is its codeword length. If no such level exists, `bits_used_o` is 0 in that cycle. Each later cycle decodes exactly one level, into the next buffer index.
- R4: A level codeword has this form: p zeros (the prefix), a 1, then s suffix bits, for a total length of p+1+s. The code number is c = (p << L) + suffix, where L is the current suffix length. An even c gives the level (c+2)/2, and an odd c gives the level −(c+1)/2.
- R5: L starts at 1 when `total_coeff_i` > 10 and `t1s_i` < 3. Otherwise it starts at 0.
- R6: When `t1s_i` < 3, the first non-trailing level has 2 added to c. When `t1s_i` is 3, nothing is added.
- R7: With L = 0 and a prefix of 14, the suffix is 4 bits long.
- R8: A prefix of 15 is an escape with a 12-bit suffix, and with L = 0 it also adds 15 to c. No codeword is longer than 28 bits.
- R9: After each level, L becomes 1 if it was 0. L then grows by 1 when |level| > 3 << (L−1), up to a limit of 6.
- R10: `done_o` is high for exactly one cycle, the cycle after the last decode cycle. With zero coefficients, that is two cycles after start, and the buffer reads all zero.
- R11: `start_i` is ignored while a block is being decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a block (accepted only while idle) |
| total_coeff_i | input | 5 | Nonzero coefficient count, 0..16 |
| t1s_i | input | 2 | Trailing-one count, at most min(3, total) |
| win_i | input | 32 | Aligned bitstream window, next bit at MSB |
| bits_used_o | output | 6 | Window bits consumed this cycle |
| done_o | output | 1 | One-cycle strobe: buffer complete |
| level_buf_o | output | 16x16 | Decoded levels in decode order, signed |

## Verification
The bench targets the following corner cases:
- Escape prefixes at both zero and nonzero suffix length. A design that mishandled either would mis-size the 12-bit suffix, lose the +15 offset, and leave the window out of step for every later level.
- The initial suffix-length threshold between 10 and 11 coefficients, and the adaptation step after a large first level. A design that got either wrong would read one suffix bit too few or too many and decode the following levels wrongly.
- Masking of the sign bits that lie past the trailing-one count, and empty blocks.
- Start pulses arriving mid-block. Accepting one would restart the decode and corrupt the buffer.

// File: rtl/t1lev_pkg.sv
package t1lev_pkg;
    localparam int T1_MAX = 3;   // trailing ones per block, fixes sign register width
    localparam int SFX_MAX = 12; // escape suffix width
    localparam int PFX_SPAN = 16; // prefix search span

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_SIGN  = 2'd1,
        PH_LEVEL = 2'd2
    } phase_e;
endpackage

// File: rtl/t1lev_sign.sv
module t1lev_sign
    import t1lev_pkg::*;
#(
    parameter int LW = 16
) (
    input  logic [T1_MAX-1:0]          sgn_i,
    input  logic [1:0]                 t1_i,
    output logic [T1_MAX-1:0]          wr_o,
    output logic [T1_MAX-1:0][LW-1:0]  val_o
);
    // one lane per possible trailing one; lane k reads bit k in stream order
    for (genvar k = 0; k < T1_MAX; k++) begin : g_lane
        assign wr_o[k]  = (t1_i > 2'(k));
        assign val_o[k] = sgn_i[T1_MAX-1-k] ? '1 : LW'(1);
    end
endmodule

// File: rtl/t1lev_level.sv
module t1lev_level
    import t1lev_pkg::*;
#(
    parameter int WIN = 32,
    parameter int LW  = 16,
    localparam int UW = $clog2(WIN+1)
) (
    input  logic [WIN-1:0] win_i,
    input  logic [2:0]     sl_i,
    input  logic           bonus_i,
    output logic [LW-1:0]  val_o,
    output logic [UW-1:0]  len_o,
    output logic [2:0]     sl_nx_o
);
    logic [3:0]         lz;
    logic [3:0]         ss;
    logic [WIN-1:0]     sh;
    logic [SFX_MAX-1:0] suf;
    logic [LW-1:0]      lc;
    logic [LW-1:0]      mag;
    logic [LW-1:0]      thr;
    logic [2:0]         s1;
    logic               esc;

    always_comb begin
        // leading-one detector over the prefix span; no one found saturates at 15
        lz = 4'd15;
        for (int i = PFX_SPAN-1; i >= 0; i--) begin
            if (win_i[WIN-1-i]) lz = 4'(i);
        end
        esc = (lz == 4'd15);
        if (esc)                               ss = 4'(SFX_MAX);
        else if (lz == 4'd14 && sl_i == 3'd0)  ss = 4'd4;
        else                                   ss = {1'b0, sl_i};

        sh  = win_i << ({1'b0, lz} + 5'd1);
        suf = sh[WIN-1 -: SFX_MAX] >> (4'(SFX_MAX) - ss);

        lc = (LW'(lz) << sl_i) + LW'(suf)
           + ((esc && sl_i == 3'd0) ? LW'(15) : '0)
           + (bonus_i ? LW'(2) : '0);
        mag   = (lc >> 1) + LW'(1);
        val_o = lc[0] ? -mag : mag;
        len_o = UW'(lz) + UW'(ss) + UW'(1);

        s1  = (sl_i == 3'd0) ? 3'd1 : sl_i;
        thr = LW'(3) << (s1 - 3'd1);
        sl_nx_o = (mag > thr && s1 < 3'd6) ? s1 + 3'd1 : s1;
    end
endmodule

// File: rtl/t1lev_dec.sv
module t1lev_dec
    import t1lev_pkg::*;
#(
    parameter int WIN  = 32,
    parameter int MAXC = 16,
    parameter int LW   = 16,
    localparam int CW  = $clog2(MAXC+1),
    localparam int IW  = $clog2(MAXC),
    localparam int UW  = $clog2(WIN+1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [CW-1:0]             total_coeff_i,
    input  logic [1:0]                t1s_i,
    input  logic [WIN-1:0]            win_i,
    output logic [UW-1:0]             bits_used_o,
    output logic                      done_o,
    output logic [MAXC-1:0][LW-1:0]   level_buf_o
);
    typedef struct packed {
        phase_e                  ph;
        logic [CW-1:0]           tc;
        logic [1:0]              t1;
        logic [T1_MAX-1:0]       sgn;
        logic [CW-1:0]           cnt;
        logic [2:0]              sl;
        logic                    done;
        logic [MAXC-1:0][LW-1:0] lb;
    } st_t;

    st_t st_d, st_q;
    logic [UW-1:0] used_d;
    logic          busy;

    logic [T1_MAX-1:0]         s_wr;
    logic [T1_MAX-1:0][LW-1:0] s_val;
    logic [LW-1:0]             l_val;
    logic [UW-1:0]             l_len;
    logic [2:0]                l_sl;
    logic                      l_bonus;

    assign l_bonus = (st_q.ph == PH_SIGN) && (st_q.t1 != 2'(T1_MAX));

    t1lev_sign #(.LW(LW)) u_sign (
        .sgn_i (st_q.sgn),
        .t1_i  (st_q.t1),
        .wr_o  (s_wr),
        .val_o (s_val)
    );

    t1lev_level #(.WIN(WIN), .LW(LW)) u_level (
        .win_i   (win_i),
        .sl_i    (st_q.sl),
        .bonus_i (l_bonus),
        .val_o   (l_val),
        .len_o   (l_len),
        .sl_nx_o (l_sl)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        used_d    = '0;
        unique case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_SIGN;
                    st_d.tc  = total_coeff_i;
                    st_d.t1  = t1s_i;
                    st_d.sgn = win_i[WIN-1 -: T1_MAX];
                    st_d.cnt = '0;
                    st_d.sl  = (total_coeff_i > CW'(10) && t1s_i != 2'(T1_MAX)) ? 3'd1 : 3'd0;
                    st_d.lb  = '0;
                    used_d   = UW'(t1s_i);
                end
            end
            PH_SIGN: begin
                // all trailing-one signs land together
                for (int k = 0; k < T1_MAX; k++) begin
                    if (s_wr[k]) st_d.lb[k] = s_val[k];
                end
                // first remaining level overlaps the sign write
                if (st_q.tc > CW'(st_q.t1)) begin
                    st_d.lb[IW'(st_q.t1)] = l_val;
                    st_d.sl  = l_sl;
                    st_d.cnt = CW'(st_q.t1) + CW'(1);
                    used_d   = l_len;
                end else begin
                    st_d.cnt = CW'(st_q.t1);
                end
                if (st_d.cnt == st_q.tc) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end else begin
                    st_d.ph = PH_LEVEL;
                end
            end
            PH_LEVEL: begin
                st_d.lb[st_q.cnt[IW-1:0]] = l_val;
                st_d.sl  = l_sl;
                st_d.cnt = st_q.cnt + CW'(1);
                used_d   = l_len;
                if (st_d.cnt == st_q.tc) begin
                    st_d.ph   = PH_IDLE;
                    st_d.done = 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy        = (st_q.ph != PH_IDLE);
    assign bits_used_o = used_d;
    assign done_o      = st_q.done;
    assign level_buf_o = st_q.lb;
endmodule

// File: rtl/t1lev_chk.sv
module t1lev_chk #(
    parameter int UW = 6
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic [1:0]    t1s_i,
    input logic          busy,
    input logic          done_o,
    input logic [UW-1:0] bits_used_o
);
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start_i) |-> bits_used_o == '0);

    a_r1_start_consume: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start_i) |-> bits_used_o == UW'(t1s_i));

    a_r8_len_max: assert property (@(posedge clk) disable iff (!rst_n)
        bits_used_o <= UW'(28));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r10_done_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy && $past(busy)));

    a_r11_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_i));
endmodule

bind t1lev_dec t1lev_chk #(.UW(UW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .t1s_i       (t1s_i),
    .busy        (busy),
    .done_o      (done_o),
    .bits_used_o (bits_used_o)
);

// File: tb/t1lev_dec_tb.sv
`timescale 1ns/1ps
module t1lev_dec_tb;
    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [4:0]        total_coeff_i = '0;
    logic [1:0]        t1s_i = '0;
    logic [31:0]       win_i = '0;
    logic [5:0]        bits_used_o;
    logic              done_o;
    logic [15:0][15:0] level_buf_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    bit sb [0:32767];
    int wp;

    always #2.5 clk = ~clk;

    t1lev_dec u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .total_coeff_i(total_coeff_i), .t1s_i(t1s_i), .win_i(win_i),
        .bits_used_o(bits_used_o), .done_o(done_o), .level_buf_o(level_buf_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int entry(input int k);
        return int'($signed(level_buf_o[k]));
    endfunction

    task automatic load_win(input int p);
        for (int j = 0; j < 32; j++) win_i[31-j] = sb[p+j];
    endtask

    task automatic fill_rand(input int base);
        for (int j = 0; j < 512; j++) sb[base+j] = (j % 14 == 13) ? 1'b1 : 1'($urandom);
        wp = base;
    endtask

    task automatic put(input int v, input int n);
        for (int j = n-1; j >= 0; j--) begin sb[wp] = v[j]; wp++; end
    endtask

    task automatic put_lvl(input int pfx, input int sfx, input int ns);
        put(0, pfx); put(1, 1); if (ns > 0) put(sfx, ns);
    endtask

    // behavioural level decode straight from the requirements
    task automatic ref_lvl(inout int p, inout int sl, input bit bonus,
                           output int v, output int len);
        int lz = 0; int ss; int suf = 0; int lc; int mag; int s0 = p;
        while (sb[p] == 1'b0) begin lz++; p++; end
        p++;
        ss = (lz == 15) ? 12 : ((lz == 14 && sl == 0) ? 4 : sl);
        for (int j = 0; j < ss; j++) begin suf = suf*2 + int'(sb[p]); p++; end
        lc = (lz << sl) + suf;
        if (lz == 15 && sl == 0) lc += 15;
        if (bonus) lc += 2;
        v = (lc % 2 == 0) ? (lc + 2) / 2 : -((lc + 1) / 2);
        if (sl == 0) sl = 1;
        mag = (v < 0) ? -v : v;
        if (mag > (3 << (sl-1)) && sl < 6) sl++;
        len = p - s0;
    endtask

    task automatic run_block(input int base, input int tc, input int t1, input bit noisy);
        int exp_used[$];
        int exp_lv[16];
        int p; int sl; int v; int len; int pos;
        for (int k = 0; k < 16; k++) exp_lv[k] = 0;
        p = base;
        exp_used.push_back(t1);
        for (int k = 0; k < t1; k++) exp_lv[k] = sb[p+k] ? -1 : 1;
        p += t1;
        sl = (tc > 10 && t1 < 3) ? 1 : 0;
        if (tc == t1) exp_used.push_back(0);
        for (int i = t1; i < tc; i++) begin
            ref_lvl(p, sl, (i == t1) && (t1 < 3), v, len);
            exp_lv[i] = v;
            exp_used.push_back(len);
        end
        pos = base;
        for (int c = 0; c < exp_used.size(); c++) begin
            @(negedge clk);
            if (c == 0) begin
                start_i = 1'b1; total_coeff_i = 5'(tc); t1s_i = 2'(t1);
            end else if (noisy) begin
                start_i = 1'b1; total_coeff_i = 5'($urandom % 17); t1s_i = 2'($urandom % 4);
            end else begin
                start_i = 1'b0;
            end
            load_win(pos);
            #1;
            chk(int'(bits_used_o) == exp_used[c], (c == 0) ? "R1 start consume" :
                (noisy ? "R11 busy start ignored" : "R3 bits used"),
                int'(bits_used_o), exp_used[c]);
            chk(done_o == 1'b0, "R10 no early done", int'(done_o), 0);
            pos += exp_used[c];
        end
        @(negedge clk);
        start_i = 1'b0;
        load_win(pos);
        #1;
        chk(done_o == 1'b1, "R10 done strobe", int'(done_o), 1);
        for (int k = 0; k < 16; k++)
            chk(entry(k) == exp_lv[k], (k < t1) ? "R2 sign entry" : "R4 level entry",
                entry(k), exp_lv[k]);
        @(negedge clk);
        #1;
        chk(done_o == 1'b0, "R10 done single", int'(done_o), 0);
        chk(bits_used_o == 6'd0, "R1 idle quiet", int'(bits_used_o), 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int base;
        base = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(done_o == 1'b0, "R10 reset done", int'(done_o), 0);
        chk(bits_used_o == 6'd0, "R1 reset quiet", int'(bits_used_o), 0);
        chk(level_buf_o == '0, "R10 reset buffer", 0, 0);

        // R10: empty block
        fill_rand(base); run_block(base, 0, 0, 0); base += 512;

        // R2: three signs, then masked third bit
        fill_rand(base); put(3'b101, 3); run_block(base, 3, 3, 0);
        chk(entry(0) == -1 && entry(1) == 1 && entry(2) == -1, "R2 three signs", entry(1), 1);
        base += 512;
        fill_rand(base); put(3'b011, 3); run_block(base, 2, 2, 0);
        chk(entry(2) == 0, "R2 masked bit", entry(2), 0);
        chk(entry(0) == 1 && entry(1) == -1, "R2 two signs", entry(1), -1);
        base += 512;

        // R7: prefix 14 at suffix length 0
        fill_rand(base); put(3'b010, 3); put_lvl(14, 11, 4); run_block(base, 4, 3, 0);
        chk(entry(3) == -13, "R7 prefix14 suffix", entry(3), -13);
        base += 512;

        // R8 and R6: escape at suffix length 0, no bonus with three ones
        fill_rand(base); put(3'b000, 3); put_lvl(15, 5, 12); run_block(base, 4, 3, 0);
        chk(entry(3) == -18, "R8 escape sl0", entry(3), -18);
        base += 512;

        // R8 and R6: escape at suffix length 1 with bonus
        fill_rand(base); put_lvl(15, 100, 12); run_block(base, 13, 0, 0);
        chk(entry(0) == 67, "R8 escape sl1", entry(0), 67);
        base += 512;

        // R5: threshold of the initial suffix length
        fill_rand(base); put(2'b00, 2); put(2'b11, 2); run_block(base, 11, 2, 0);
        chk(entry(2) == -2, "R5 start sl1", entry(2), -2);
        base += 512;
        fill_rand(base); put(2'b00, 2); put(2'b11, 2); run_block(base, 10, 2, 0);
        chk(entry(2) == 2, "R5 start sl0", entry(2), 2);
        base += 512;

        // R9: adaptation after a large first level
        fill_rand(base); put_lvl(4, 0, 0); put_lvl(0, 3, 2); put_lvl(0, 0, 2);
        run_block(base, 3, 0, 0);
        chk(entry(0) == 4 && entry(1) == -2 && entry(2) == 1, "R9 sl step", entry(1), -2);
        base += 512;

        // random blocks; some with start held during decode (R11)
        for (int b = 0; b < 40; b++) begin
            int tc; int t1; int lim;
            tc = $urandom % 17;
            lim = (tc < 3) ? tc : 3;
            t1 = $urandom % (lim + 1);
            fill_rand(base);
            run_block(base, tc, t1, (b % 4) == 3);
            base += 512;
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule